// File: doc/BRIEF.md
# Interval Mask Tile Classifier

This block decides, tile by tile, how an attention kernel should treat a block of the score matrix under a structured mask. The mask is not kept as a dense bitmap. Each key column holds two row intervals, a lower one and an upper one, and a row of that column is masked when it falls inside either interval. Software fills the per-column bounds through a simple write port, one column per write. Mask storage therefore grows linearly with sequence length.

The compute engine asks about a tile by giving a query-row tile index and a key-column tile index. The block reads the bounds of the tile's columns, one column per clock, and evaluates every element of the tile. It then returns one of three classes:

- skip: every element is masked, so the tile can be pruned.
- dense: no element is masked, so the tile can be computed without a mask.
- partial: some elements are masked.

With each answer it returns the element bitmap. Requests can be issued back to back, and one tile completes every TILE_COLS cycles.

Top module: `mask_tile_skipper`

## Requirements
- R1: A cycle with `ld_we` high stores the four bounds of column `ld_col`. There is one entry per key column, SEQ_LEN entries in all, and a stored entry is used by every later tile that covers that column.
- R2: Element (row r, column c) is masked when `lo_start[c] <= r < lo_end[c]` or `up_start[c] <= r < up_end[c]`. Ends are exclusive, and an interval whose start is greater than or equal to its end is empty. The bitmap bit for the element at relative row i and relative column j of the tile is bit `j*TILE_ROWS + i`, and 1 means masked. Absolute row is `row_tile*TILE_ROWS + i` and absolute column is `col_tile*TILE_COLS + j`.
- R3: When every element of the tile is masked, `rsp_class` is 0 (skip), including the case where the coverage comes only from the union of the two intervals of a column.
- R4: When no element of the tile is masked, `rsp_class` is 1 (dense) and the bitmap is all zeros.
- R5: When the tile has both masked and unmasked elements, `rsp_class` is 2 (partial).
- R6: `rsp_valid` is high for one cycle, exactly TILE_COLS+1 rising edges after the edge that accepts the request. The response carries the requested row and column tile indices.
- R7: `req_ready` is high when the block is idle, and also during the last column cycle of a tile in progress. Back-to-back requests are accepted every TILE_COLS cycles and answered in request order.
- R8: A bound write to a column in the same cycle that the column is being read for a tile gives that tile the previous contents. The new bounds apply to later tiles.
- R9: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R10: A `req_valid` held while `req_ready` is low is not accepted. It produces no extra response and does not disturb the tile in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Bound write enable |
| ld_col | input | COL_W | Key column being written |
| ld_lo_start | input | IDX_W | Lower interval first masked row |
| ld_lo_end | input | IDX_W | Lower interval end (exclusive) |
| ld_up_start | input | IDX_W | Upper interval first masked row |
| ld_up_end | input | IDX_W | Upper interval end (exclusive) |
| req_valid | input | 1 | Tile query request |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_row_tile | input | RT_W | Query-row tile index |
| req_col_tile | input | CT_W | Key-column tile index |
| rsp_valid | output | 1 | Response pulse |
| rsp_class | output | 2 | 0 skip, 1 dense, 2 partial |
| rsp_bitmap | output | TILE_ROWS*TILE_COLS | Element mask, column-major |
| rsp_row_tile | output | RT_W | Echoed row tile index |
| rsp_col_tile | output | CT_W | Echoed column tile index |

## Verification
Two functions can land in the same cycle.

The first overlap is a bound write and the tile read of the same column. The bench provokes it by writing the first column of a tile during the cycle that issues that column's read. It judges the result by requiring the old pattern in that response and the new pattern in the next query of the same tile.

The second overlap is the last column of one tile and the acceptance of the next. The bench holds a second request pending throughout the first tile. It checks three things:
- `req_ready` stays low until the last column.
- Exactly two responses appear, at the predicted edges.
- Each response has its own correct class.

// File: rtl/mtile_pkg.sv
package mtile_pkg;
  typedef enum logic [1:0] {
    TILE_SKIP    = 2'd0,
    TILE_DENSE   = 2'd1,
    TILE_PARTIAL = 2'd2
  } tile_class_e;
endpackage

// File: rtl/mt_bound_ram.sv
module mt_bound_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 28,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first: a same-edge write is seen only by later reads
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  p_waddr_range_r1: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
  p_raddr_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(raddr) < DEPTH);
endmodule

// File: rtl/mt_issue_seq.sv
module mt_issue_seq #(
  parameter int TILE_COLS = 4,
  parameter int COL_W     = 6,
  parameter int RT_W      = 4,
  parameter int CT_W      = 4,
  parameter int K_W       = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [RT_W-1:0] req_row_tile,
  input  logic [CT_W-1:0] req_col_tile,
  output logic            req_ready,
  output logic [COL_W-1:0] rd_addr,
  output logic            iss_v,
  output logic [K_W-1:0]  iss_k,
  output logic [RT_W-1:0] iss_row,
  output logic [CT_W-1:0] iss_col
);
  localparam logic [K_W-1:0] K_LAST = K_W'(TILE_COLS - 1);

  logic            busy;
  logic [K_W-1:0]  k;
  logic [RT_W-1:0] row_q;
  logic [CT_W-1:0] col_q;
  logic            accept;

  assign req_ready = !busy || (k == K_LAST);
  assign accept    = req_valid && req_ready;
  assign rd_addr   = COL_W'(col_q) * COL_W'(TILE_COLS) + COL_W'(k);
  assign iss_v     = busy;
  assign iss_k     = k;
  assign iss_row   = row_q;
  assign iss_col   = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      k     <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      k     <= '0;
      row_q <= req_row_tile;
      col_q <= req_col_tile;
    end else if (busy) begin
      if (k == K_LAST) busy <= 1'b0;
      else             k    <= k + 1'b1;
    end
  end

  p_accept_starts_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && k == '0));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (k <= K_LAST));
  p_hold_midtile_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && k != K_LAST && req_valid) |=> (busy && k == $past(k) + 1'b1 && $stable(col_q)));
endmodule

// File: rtl/mt_col_eval.sv
module mt_col_eval #(
  parameter int TILE_ROWS = 4,
  parameter int IDX_W     = 7,
  parameter int RT_W      = 4
) (
  input  logic [RT_W-1:0]      row_tile,
  input  logic [4*IDX_W-1:0]   bounds,
  output logic [TILE_ROWS-1:0] col_mask
);
  logic [IDX_W-1:0] lo_s, lo_e, up_s, up_e;
  assign {lo_s, lo_e, up_s, up_e} = bounds;

  logic [IDX_W-1:0] base;
  assign base = IDX_W'(row_tile) * IDX_W'(TILE_ROWS);

  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_row
    logic [IDX_W-1:0] ridx;
    assign ridx = base + IDX_W'(r);
    assign col_mask[r] = ((ridx >= lo_s) && (ridx < lo_e)) ||
                         ((ridx >= up_s) && (ridx < up_e));
  end
endmodule

// File: rtl/mt_tile_accum.sv
module mt_tile_accum
  import mtile_pkg::*;
#(
  parameter int TILE_ROWS = 4,
  parameter int TILE_COLS = 4,
  parameter int IDX_W     = 7,
  parameter int RT_W      = 4,
  parameter int CT_W      = 4,
  parameter int K_W       = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           iss_v,
  input  logic [K_W-1:0]                 iss_k,
  input  logic [RT_W-1:0]                iss_row,
  input  logic [CT_W-1:0]                iss_col,
  input  logic [4*IDX_W-1:0]             rdata,
  output logic                           rsp_valid,
  output logic [1:0]                     rsp_class,
  output logic [TILE_ROWS*TILE_COLS-1:0] rsp_bitmap,
  output logic [RT_W-1:0]                rsp_row_tile,
  output logic [CT_W-1:0]                rsp_col_tile
);
  localparam int BM_W = TILE_ROWS * TILE_COLS;
  localparam logic [K_W-1:0] K_LAST = K_W'(TILE_COLS - 1);

  logic            s_v;
  logic [K_W-1:0]  s_k;
  logic [RT_W-1:0] s_row;
  logic [CT_W-1:0] s_col;

  logic [BM_W-1:0] acc_bm, nxt_bm;
  logic            acc_all, acc_none, nxt_all, nxt_none;
  logic [TILE_ROWS-1:0] col_mask;
  tile_class_e     cls;

  mt_col_eval #(.TILE_ROWS(TILE_ROWS), .IDX_W(IDX_W), .RT_W(RT_W)) u_eval (
    .row_tile(s_row),
    .bounds  (rdata),
    .col_mask(col_mask)
  );

  always_comb begin
    logic first;
    first    = (s_k == '0);
    nxt_all  = (first ? 1'b1 : acc_all)  && (&col_mask);
    nxt_none = (first ? 1'b1 : acc_none) && !(|col_mask);
    nxt_bm   = first ? '0 : acc_bm;
    for (int c = 0; c < TILE_COLS; c++) begin
      if (s_k == K_W'(c)) nxt_bm[c*TILE_ROWS +: TILE_ROWS] = col_mask;
    end
    if (nxt_all)       cls = TILE_SKIP;
    else if (nxt_none) cls = TILE_DENSE;
    else               cls = TILE_PARTIAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v          <= 1'b0;
      s_k          <= '0;
      s_row        <= '0;
      s_col        <= '0;
      acc_bm       <= '0;
      acc_all      <= 1'b0;
      acc_none     <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_class    <= 2'd0;
      rsp_bitmap   <= '0;
      rsp_row_tile <= '0;
      rsp_col_tile <= '0;
    end else begin
      s_v   <= iss_v;
      s_k   <= iss_k;
      s_row <= iss_row;
      s_col <= iss_col;
      if (s_v) begin
        acc_bm   <= nxt_bm;
        acc_all  <= nxt_all;
        acc_none <= nxt_none;
      end
      rsp_valid <= s_v && (s_k == K_LAST);
      if (s_v && (s_k == K_LAST)) begin
        rsp_class    <= cls;
        rsp_bitmap   <= nxt_bm;
        rsp_row_tile <= s_row;
        rsp_col_tile <= s_col;
      end
    end
  end

  p_skip_all_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_class == 2'd0) |-> (&rsp_bitmap));
  p_dense_no_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_class == 2'd1) |-> (rsp_bitmap == '0));
  p_partial_mixed_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_class == 2'd2) |-> ((|rsp_bitmap) && !(&rsp_bitmap)));
  p_class_legal_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_class != 2'd3));

  if (TILE_COLS > 1) begin : g_pulse_chk
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);
  end
endmodule

// File: rtl/mask_tile_skipper.sv
module mask_tile_skipper #(
  parameter int SEQ_LEN   = 64,
  parameter int TILE_ROWS = 4,
  parameter int TILE_COLS = 4,
  localparam int IDX_W = $clog2(SEQ_LEN + 1),
  localparam int COL_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int NRT   = SEQ_LEN / TILE_ROWS,
  localparam int NCT   = SEQ_LEN / TILE_COLS,
  localparam int RT_W  = (NRT > 1) ? $clog2(NRT) : 1,
  localparam int CT_W  = (NCT > 1) ? $clog2(NCT) : 1,
  localparam int BM_W  = TILE_ROWS * TILE_COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic [COL_W-1:0] ld_col,
  input  logic [IDX_W-1:0] ld_lo_start,
  input  logic [IDX_W-1:0] ld_lo_end,
  input  logic [IDX_W-1:0] ld_up_start,
  input  logic [IDX_W-1:0] ld_up_end,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [RT_W-1:0]  req_row_tile,
  input  logic [CT_W-1:0]  req_col_tile,
  output logic             rsp_valid,
  output logic [1:0]       rsp_class,
  output logic [BM_W-1:0]  rsp_bitmap,
  output logic [RT_W-1:0]  rsp_row_tile,
  output logic [CT_W-1:0]  rsp_col_tile
);
  localparam int K_W   = (TILE_COLS > 1) ? $clog2(TILE_COLS) : 1;
  localparam int WORD  = 4 * IDX_W;

  logic [COL_W-1:0] rd_addr;
  logic [WORD-1:0]  rdata;
  logic             iss_v;
  logic [K_W-1:0]   iss_k;
  logic [RT_W-1:0]  iss_row;
  logic [CT_W-1:0]  iss_col;

  mt_bound_ram #(.DEPTH(SEQ_LEN), .WIDTH(WORD), .AW(COL_W)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (ld_we),
    .waddr(ld_col),
    .wdata({ld_lo_start, ld_lo_end, ld_up_start, ld_up_end}),
    .raddr(rd_addr),
    .rdata(rdata)
  );

  mt_issue_seq #(.TILE_COLS(TILE_COLS), .COL_W(COL_W), .RT_W(RT_W),
                 .CT_W(CT_W), .K_W(K_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_row_tile(req_row_tile),
    .req_col_tile(req_col_tile),
    .req_ready   (req_ready),
    .rd_addr     (rd_addr),
    .iss_v       (iss_v),
    .iss_k       (iss_k),
    .iss_row     (iss_row),
    .iss_col     (iss_col)
  );

  mt_tile_accum #(.TILE_ROWS(TILE_ROWS), .TILE_COLS(TILE_COLS), .IDX_W(IDX_W),
                  .RT_W(RT_W), .CT_W(CT_W), .K_W(K_W)) u_acc (
    .clk         (clk),
    .rst         (rst),
    .iss_v       (iss_v),
    .iss_k       (iss_k),
    .iss_row     (iss_row),
    .iss_col     (iss_col),
    .rdata       (rdata),
    .rsp_valid   (rsp_valid),
    .rsp_class   (rsp_class),
    .rsp_bitmap  (rsp_bitmap),
    .rsp_row_tile(rsp_row_tile),
    .rsp_col_tile(rsp_col_tile)
  );

  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !rsp_valid));
endmodule

// File: tb/tb_mask_tile_skipper.sv
module tb_mask_tile_skipper;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int TR = 4;
  localparam int TC = 4;
  localparam int BM = TR * TC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0;
  logic [5:0] ld_col = '0;
  logic [6:0] ld_lo_start = '0, ld_lo_end = '0, ld_up_start = '0, ld_up_end = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_row_tile = '0, req_col_tile = '0;
  logic rsp_valid;
  logic [1:0] rsp_class;
  logic [BM-1:0] rsp_bitmap;
  logic [3:0] rsp_row_tile, rsp_col_tile;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int m_ls[N], m_le[N], m_us[N], m_ue[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_tile_skipper #(.SEQ_LEN(N), .TILE_ROWS(TR), .TILE_COLS(TC)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_col(ld_col),
    .ld_lo_start(ld_lo_start), .ld_lo_end(ld_lo_end),
    .ld_up_start(ld_up_start), .ld_up_end(ld_up_end),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row_tile(req_row_tile), .req_col_tile(req_col_tile),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_bitmap(rsp_bitmap),
    .rsp_row_tile(rsp_row_tile), .rsp_col_tile(rsp_col_tile)
  );

  function automatic logic [BM-1:0] model_bm(int rt, int ct);
    logic [BM-1:0] b = '0;
    for (int j = 0; j < TC; j++)
      for (int i = 0; i < TR; i++) begin
        int r = rt*TR + i;
        int c = ct*TC + j;
        b[j*TR+i] = (m_ls[c] <= r && r < m_le[c]) || (m_us[c] <= r && r < m_ue[c]);
      end
    return b;
  endfunction

  function automatic logic [1:0] model_cls(logic [BM-1:0] b);
    if (&b) return 2'd0;
    if (b == '0) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(string req, bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_rsp(string req, int rt, int ct, logic [BM-1:0] eb);
    logic [1:0] ec = model_cls(eb);
    chk(req, rsp_valid === 1'b1, "rsp_valid", int'(rsp_valid), 1);
    chk(req, rsp_class === ec, "class", int'(rsp_class), int'(ec));
    chk(req, rsp_bitmap === eb, "bitmap", int'(rsp_bitmap), int'(eb));
    chk(req, rsp_row_tile == 4'(rt) && rsp_col_tile == 4'(ct), "tile",
        int'({rsp_row_tile, rsp_col_tile}), (rt << 4) | ct);
  endtask

  task automatic load_col(int c, int a, int b, int d, int e);
    @(negedge clk);
    ld_we = 1; ld_col = 6'(c);
    ld_lo_start = 7'(a); ld_lo_end = 7'(b); ld_up_start = 7'(d); ld_up_end = 7'(e);
    m_ls[c] = a; m_le[c] = b; m_us[c] = d; m_ue[c] = e;
    @(negedge clk);
    ld_we = 0;
  endtask

  // one tile; R6 latency checked as silence before and pulse at edge TC+1
  task automatic query(string req, int rt, int ct);
    logic [BM-1:0] eb = model_bm(rt, ct);
    @(negedge clk);
    chk("R7", req_ready === 1'b1, "ready idle", int'(req_ready), 1);
    req_valid = 1; req_row_tile = 4'(rt); req_col_tile = 4'(ct);
    @(negedge clk);
    req_valid = 0;
    repeat (TC) @(negedge clk);
    chk("R6", rsp_valid === 1'b0, "early rsp", int'(rsp_valid), 0);
    @(negedge clk);
    check_rsp(req, rt, ct, eb);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk("R9", rsp_valid === 1'b0, "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R9", req_ready === 1'b1, "req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_load_all;  // R1
    for (int c = 16; c < N; c++) load_col(c, 0, c, 60, 60);
    load_col(0, 3, 3, 9, 2);    // both empty, one with start > end
    load_col(1, 0, 0, 4, 4);
    load_col(2, 10, 20, 30, 40);
    load_col(3, 4, 8, 4, 4);
    load_col(4, 0, 5, 5, 64);   // union covers all rows
    load_col(5, 0, 2, 2, 64);
    load_col(6, 0, 64, 0, 0);
    load_col(7, 0, 1, 1, 64);
    load_col(8, 1, 3, 6, 6);
    load_col(9, 0, 0, 2, 4);
    load_col(10, 0, 1, 3, 9);
    load_col(11, 0, 4, 0, 0);
    for (int c = 12; c < 16; c++) load_col(c, 0, 4, 7, 7);
  endtask

  task automatic t_dense;     query("R4", 0, 0); query("R5", 1, 0); endtask
  task automatic t_skip;      query("R3", 0, 1); query("R3", 15, 1); endtask
  task automatic t_excl_end;  query("R2", 0, 3); query("R2", 1, 3); endtask
  task automatic t_partial;   query("R5", 0, 2); query("R2", 2, 2); endtask
  task automatic t_sweep;
    query("R1", 4, 4); query("R3", 3, 4); query("R3", 4, 8);
    query("R4", 8, 4); query("R2", 9, 9); query("R1", 15, 15);
  endtask

  task automatic t_back_to_back;  // R7, R10
    logic [BM-1:0] ea = model_bm(0, 2);
    logic [BM-1:0] eb = model_bm(0, 3);
    int pulses = 0;
    @(negedge clk);
    req_valid = 1; req_row_tile = 4'd0; req_col_tile = 4'd2;
    @(negedge clk);                       // after accept edge e0
    req_row_tile = 4'd0; req_col_tile = 4'd3;
    for (int i = 1; i <= 2*TC + 2; i++) begin
      @(negedge clk);
      if (i < TC - 1)
        chk("R10", req_ready === 1'b0, "ready mid tile", int'(req_ready), 0);
      if (i == TC - 1)
        chk("R7", req_ready === 1'b1, "ready last col", int'(req_ready), 1);
      if (i == TC) req_valid = 0;
      if (rsp_valid === 1'b1) pulses++;
      if (i == TC + 1) check_rsp("R7", 0, 2, ea);
      if (i == 2*TC + 1) check_rsp("R7", 0, 3, eb);
    end
    chk("R10", pulses == 2, "response count", pulses, 2);
  endtask

  task automatic t_collision;  // R8
    logic [BM-1:0] eold = model_bm(0, 2);
    @(negedge clk);
    req_valid = 1; req_row_tile = 4'd0; req_col_tile = 4'd2;
    @(negedge clk);                       // column 8 read is issued now
    req_valid = 0;
    ld_we = 1; ld_col = 6'd8;
    ld_lo_start = 7'd0; ld_lo_end = 7'd4; ld_up_start = 7'd0; ld_up_end = 7'd0;
    @(negedge clk);
    ld_we = 0;
    repeat (TC - 1) @(negedge clk);
    chk("R6", rsp_valid === 1'b0, "early rsp", int'(rsp_valid), 0);
    @(negedge clk);
    check_rsp("R8", 0, 2, eold);
    m_ls[8] = 0; m_le[8] = 4; m_us[8] = 0; m_ue[8] = 0;
    query("R8", 0, 2);
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin m_ls[c] = 0; m_le[c] = 0; m_us[c] = 0; m_ue[c] = 0; end
    t_reset;
    t_load_all;
    t_dense;
    t_skip;
    t_excl_end;
    t_partial;
    t_sweep;
    t_back_to_back;
    t_collision;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule